// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit

This block arbitrates among five interrupt sources for a small 4-bit processor core. The sources, from highest to lowest priority, are the first divider, the first timer, an input-port change, the second divider and the second timer. The block holds each incoming request in an event flag, qualifies the flag with an interrupt enable, and selects the winning source. It then offers that source's fixed program address to the core over a valid/ready channel. A separate set of hold-release enables turns pending flags into a wake signal, whatever the interrupt enables say.

After reset the channel first offers address 0000H, the start address. Once the core accepts a vector, the block clears that flag and offers nothing more until the core signals a return. Flags that lost the arbitration stay latched and are offered later. The port source also fires on a falling edge of any of its input pins. The pins pass through a synchronizer before edge detection.

The vector channel follows valid/ready rules. The unit drives `vec_valid_o` only from its own registers. Once it raises valid, it holds both the offer and the address until a cycle in which `vec_ready_i` is high. A transfer in that cycle is the acknowledge. The core may hold ready low for any number of cycles.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, the first offer has address 0000H. It stays offered until accepted, and no other vector is offered before it.
- R2: Source index 0 (first divider) returns 0004H, index 1 (first timer) 0008H, index 2 (port) 000CH, index 3 (second divider) 0014H and index 4 (second timer) 0020H.
- R3: When several enabled flags are pending, the lowest source index is offered first.
- R4: A `tick_i` bit sets its event flag at the next clock edge. The flag stays set until that source is accepted or the matching `flag_clr_i` bit is pulsed. When a set and a clear of the same flag fall in the same cycle, the set wins.
- R5: A flag whose `irq_en_i` bit is 0 is never offered, but it stays latched. Setting the enable later makes the unit offer it.
- R6: A high-to-low transition on any `port_pin_i` bit, seen after a two-stage synchronizer, sets the port flag (index 2). Rising transitions set nothing. Several pins falling together give one event.
- R7: Accepting a non-reset vector clears that source's flag and blocks all further offers until a `ret_i` pulse. Other pending flags are kept and are offered after the return.
- R8: While `vec_valid_o` is high and `vec_ready_i` is low, valid stays high and `vec_addr_o` stays unchanged, even if a higher-priority flag arrives.
- R9: `wake_o` is high exactly when some event flag is set and its `hold_en_i` bit is 1. This holds independently of `irq_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 5 | One-cycle request pulses, bit index = source index |
| port_pin_i | input | PORT_W | Asynchronous port pins, idle high |
| irq_en_i | input | 5 | Interrupt enables per source |
| hold_en_i | input | 5 | Hold-release enables per source |
| flag_clr_i | input | 5 | One-cycle event-flag clear pulses |
| vec_valid_o | output | 1 | Vector offer valid |
| vec_ready_i | input | 1 | Core ready to load the vector |
| vec_addr_o | output | 14 | Offered program address |
| ret_i | input | 1 | Return-from-interrupt strobe |
| wake_o | output | 1 | Hold-release wake request |

## Verification
The properties assume that the core pulses `ret_i` only after a transfer, never while no interrupt is in service. They also assume that the port pins sit high when reset is released, so the synchronizer, which resets to ones, sees no false edge. The stimulus keeps within these limits: it holds every pin high through reset, and it issues a return only after the scoreboard has matched an accepted vector. Ready is driven low for stretches of time, and higher-priority requests arrive during those stretches, so the stability rule is exercised against real competition.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  localparam int NSRC  = 5;
  localparam int IDX_W = $clog2(NSRC);
  localparam int VEC_W = 14;

  typedef enum logic [IDX_W-1:0] {
    SRC_DIV0  = 3'd0,
    SRC_TMR0  = 3'd1,
    SRC_PORT  = 3'd2,
    SRC_DIV1  = 3'd3,
    SRC_TMR1  = 3'd4
  } src_e;

  localparam logic [VEC_W-1:0] RESET_VEC = '0;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    logic [VEC_W-1:0] v;
    case (idx)
      SRC_DIV0: v = 14'h0004;
      SRC_TMR0: v = 14'h0008;
      SRC_PORT: v = 14'h000C;
      SRC_DIV1: v = 14'h0014;
      SRC_TMR1: v = 14'h0020;
      default:  v = 14'h0004;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/irq_port_fall.sv
module irq_port_fall #(
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_i,
  output logic              fall_o
);
  logic [PORT_W-1:0] stage_q [SYNC_STAGES];
  logic [PORT_W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '1;
        end else begin
          if (s == 0) stage_q[s] <= pin_i;
          else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= stage_q[SYNC_STAGES-1];
  end

  // any pin that was high last cycle and is low now
  assign fall_o = |(prev_q & ~stage_q[SYNC_STAGES-1]);
endmodule

// File: rtl/irq_event_flags.sv
module irq_event_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_o[i] <= 1'b0;
        else if (set_i[i]) flag_o[i] <= 1'b1;
        else if (clr_i[i]) flag_o[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N     = 5,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N:0]         taken;
  logic [IDX_W-1:0]   idx_chain [N+1];

  assign taken[0]     = 1'b0;
  assign idx_chain[0] = '0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_stage
      // lower index wins: later stages only fill in if nothing earlier did
      assign taken[i+1]     = taken[i] | req_i[i];
      assign idx_chain[i+1] = (!taken[i] && req_i[i]) ? IDX_W'(i) : idx_chain[i];
    end
  endgenerate

  assign any_o = taken[N];
  assign idx_o = idx_chain[N];
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_vec_pkg::*;
#(
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   tick_i,
  input  logic [PORT_W-1:0] port_pin_i,
  input  logic [NSRC-1:0]   irq_en_i,
  input  logic [NSRC-1:0]   hold_en_i,
  input  logic [NSRC-1:0]   flag_clr_i,
  output logic              vec_valid_o,
  input  logic              vec_ready_i,
  output logic [VEC_W-1:0]  vec_addr_o,
  input  logic              ret_i,
  output logic              wake_o
);
  logic              port_fall;
  logic [NSRC-1:0]   set_vec, clr_vec, flags, pending, acc_oh;
  logic              any_pend;
  logic [IDX_W-1:0]  win_idx;
  logic              rst_pend_q, offer_q, busy_q;
  logic [IDX_W-1:0]  offer_idx_q;
  logic              accept;

  irq_port_fall #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_port (
    .clk(clk), .rst_n(rst_n), .pin_i(port_pin_i), .fall_o(port_fall)
  );

  always_comb begin
    set_vec = tick_i;
    set_vec[SRC_PORT] = tick_i[SRC_PORT] | port_fall;
  end

  assign accept = vec_valid_o && vec_ready_i;

  always_comb begin
    acc_oh = '0;
    if (accept && !rst_pend_q) acc_oh[offer_idx_q] = 1'b1;
  end

  assign clr_vec = flag_clr_i | acc_oh;

  irq_event_flags #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .flag_o(flags)
  );

  assign pending = flags & irq_en_i;

  irq_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
    .req_i(pending), .any_o(any_pend), .idx_o(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend_q  <= 1'b1;
      offer_q     <= 1'b0;
      offer_idx_q <= '0;
      busy_q      <= 1'b0;
    end else begin
      if (accept) begin
        if (rst_pend_q) begin
          rst_pend_q <= 1'b0;
        end else begin
          offer_q <= 1'b0;
          busy_q  <= 1'b1;
        end
      end else if (ret_i) begin
        busy_q <= 1'b0;
      end
      // capture a winner only when idle; payload then frozen until accepted
      if (!rst_pend_q && !offer_q && !busy_q && any_pend) begin
        offer_q     <= 1'b1;
        offer_idx_q <= win_idx;
      end
    end
  end

  assign vec_valid_o = rst_pend_q | offer_q;
  assign vec_addr_o  = rst_pend_q ? RESET_VEC : vec_of(offer_idx_q);
  assign wake_o      = |(flags & hold_en_i);
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk
  import irq_vec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             vec_valid_o,
  input logic             vec_ready_i,
  input logic [VEC_W-1:0] vec_addr_o,
  input logic [NSRC-1:0]  hold_en_i,
  input logic             wake_o
);
  logic seen_xfer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          seen_xfer_q <= 1'b0;
    else if (vec_valid_o && vec_ready_i) seen_xfer_q <= 1'b1;
  end

  AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_xfer_q |-> (vec_valid_o && vec_addr_o == RESET_VEC)); // R1

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && seen_xfer_q) |-> (vec_addr_o == 14'h0004 || vec_addr_o == 14'h0008 ||
      vec_addr_o == 14'h000C || vec_addr_o == 14'h0014 || vec_addr_o == 14'h0020)); // R2

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_ready_i) |=> (vec_valid_o && $stable(vec_addr_o))); // R8

  AST_MASK_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && vec_ready_i && vec_addr_o != RESET_VEC) |=> !vec_valid_o); // R7

  AST_WAKE_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (hold_en_i != '0)); // R9
endmodule

bind irq_vector_unit irq_vector_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vec_valid_o(vec_valid_o), .vec_ready_i(vec_ready_i),
  .vec_addr_o(vec_addr_o), .hold_en_i(hold_en_i), .wake_o(wake_o)
);

// File: tb/irq_vector_unit_tb_top.sv
module irq_vector_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  tick = '0;
  logic [3:0]  pins = 4'hF;
  logic [4:0]  irq_en = '0;
  logic [4:0]  hold_en = '0;
  logic [4:0]  flag_clr = '0;
  logic        vec_valid;
  logic        vec_ready = 1'b0;
  logic [13:0] vec_addr;
  logic        ret = 1'b0;
  logic        wake;

  int checks = 0;
  int fails  = 0;
  logic [13:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  irq_vector_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .port_pin_i(pins), .irq_en_i(irq_en),
    .hold_en_i(hold_en), .flag_clr_i(flag_clr), .vec_valid_o(vec_valid),
    .vec_ready_i(vec_ready), .vec_addr_o(vec_addr), .ret_i(ret), .wake_o(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every transfer is compared with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && vec_valid && vec_ready) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected transfer", {18'd0, vec_addr}, 32'hFFFF);
      end else begin
        chk(tag_q.pop_front(), {18'd0, vec_addr}, {18'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_tick(input logic [4:0] m);
    step(1); tick = m; step(1); tick = '0;
  endtask

  task automatic pulse_clr(input logic [4:0] m);
    step(1); flag_clr = m; step(1); flag_clr = '0;
  endtask

  task automatic expect_vec(input logic [13:0] a, input string tag, input bit do_ret);
    exp_q.push_back(a); tag_q.push_back(tag);
    step(1); vec_ready = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #2;
      if (exp_q.size() == 0) break;
    end
    vec_ready = 1'b0;
    if (exp_q.size() != 0) begin
      chk({tag, " timeout"}, 32'(exp_q.size()), 0);
      exp_q.delete(); tag_q.delete();
    end
    step(3);
    chk("R7 no offer before return", {31'd0, vec_valid}, 0);
    if (do_ret) begin ret = 1'b1; step(1); ret = 1'b0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    @(negedge clk);
    chk("R1 reset valid", {31'd0, vec_valid}, 1);
    chk("R1 reset addr", {18'd0, vec_addr}, 0);
    chk("R9 wake idle", {31'd0, wake}, 0);
    expect_vec(14'h0000, "R1 reset vector", 1'b0);

    irq_en = 5'h1F;
    // R2: each source alone
    pulse_tick(5'b00001); expect_vec(14'h0004, "R2 div0", 1'b1);
    pulse_tick(5'b00010); expect_vec(14'h0008, "R2 tmr0", 1'b1);
    pulse_tick(5'b00100); expect_vec(14'h000C, "R2 port", 1'b1);
    pulse_tick(5'b01000); expect_vec(14'h0014, "R2 div1", 1'b1);
    pulse_tick(5'b10000); expect_vec(14'h0020, "R2 tmr1", 1'b1);

    // R3/R7: all pending at once, serviced in priority order
    pulse_tick(5'b11111);
    expect_vec(14'h0004, "R3 first", 1'b1);
    expect_vec(14'h0008, "R3 second", 1'b1);
    expect_vec(14'h000C, "R3 third", 1'b1);
    expect_vec(14'h0014, "R3 fourth", 1'b1);
    expect_vec(14'h0020, "R3 fifth", 1'b1);

    // R3: two non-adjacent sources
    pulse_tick(5'b10100);
    expect_vec(14'h000C, "R3 port before tmr1", 1'b1);
    expect_vec(14'h0020, "R7 kept tmr1 after return", 1'b1);

    // R5: disabled flag stays latched
    irq_en = 5'b11101;
    pulse_tick(5'b00010);
    step(6); @(negedge clk);
    chk("R5 disabled not offered", {31'd0, vec_valid}, 0);
    irq_en = 5'h1F;
    expect_vec(14'h0008, "R5 offered once enabled", 1'b1);

    // R4: clear removes a latched flag
    irq_en = 5'b11101;
    pulse_tick(5'b00010);
    pulse_clr(5'b00010);
    irq_en = 5'h1F;
    step(6); @(negedge clk);
    chk("R4 cleared flag not offered", {31'd0, vec_valid}, 0);

    // R9: wake independent of interrupt enable
    irq_en = 5'b00000; hold_en = 5'b01000;
    pulse_tick(5'b01000);
    @(negedge clk);
    chk("R9 wake on held flag", {31'd0, wake}, 1);
    chk("R5 no offer with enables off", {31'd0, vec_valid}, 0);
    hold_en = 5'b00100;
    @(negedge clk);
    chk("R9 wake needs matching hold bit", {31'd0, wake}, 0);
    hold_en = 5'b01000;
    pulse_clr(5'b01000);
    @(negedge clk);
    chk("R4 clear drops wake", {31'd0, wake}, 0);

    // R4: set beats clear in the same cycle
    step(1); tick = 5'b01000; flag_clr = 5'b01000; step(1); tick = '0; flag_clr = '0;
    @(negedge clk);
    chk("R4 set wins over clear", {31'd0, wake}, 1);
    pulse_clr(5'b01000);
    hold_en = '0; irq_en = 5'h1F;

    // R6: port falling edges
    step(1); pins = 4'b1101;
    expect_vec(14'h000C, "R6 pin fall", 1'b1);
    step(1); pins = 4'hF;
    step(8); @(negedge clk);
    chk("R6 rise ignored", {31'd0, vec_valid}, 0);
    step(1); pins = 4'b0110;
    expect_vec(14'h000C, "R6 two pins one event", 1'b1);
    step(6); @(negedge clk);
    chk("R6 single event only", {31'd0, vec_valid}, 0);
    step(1); pins = 4'hF; step(8);

    // R8: back-pressure keeps offer stable against a higher priority arrival
    pulse_tick(5'b10000);
    step(4); @(negedge clk);
    chk("R8 offer waiting", {31'd0, vec_valid}, 1);
    chk("R8 addr tmr1", {18'd0, vec_addr}, 32'h20);
    pulse_tick(5'b00001);
    step(4); @(negedge clk);
    chk("R8 addr held", {18'd0, vec_addr}, 32'h20);
    expect_vec(14'h0020, "R8 held vector delivered", 1'b1);
    expect_vec(14'h0004, "R7 div0 after return", 1'b1);

    step(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule